// File: doc/BRIEF.md
# CAN Receive Mailbox Move-In Controller

This block owns one bank of receive mailboxes for a CAN controller. Completed frames arrive from the receive serial side, each already tagged with the index of the mailbox that won matching, plus its identifier, length code and payload. The frame is parked in one of two shared staging slots. From there a copy engine moves it into the mailbox over a fixed window of `COPY_CYC` clock cycles. During that window the mailbox status code carries a busy sub-bit, so the CPU can tell that the contents are still in motion.

The CPU sees the bank through a word-wide register port. Reading a mailbox status word can lock that mailbox against further move-in, so software can drain it consistently. The lock is released by reading the free-running timer or the status word of another mailbox. While a mailbox is locked, a frame bound for it waits in staging. Writing a non-receive code such as INACTIVE to a mailbox silently discards any frame already routed to it. Each mailbox has one interrupt flag, raised on move-in and cleared by writing one.

Top module: `rxmb_movein`

## Requirements
- R1: After reset every mailbox status code reads EMPTY, all interrupt flags are 0 and `frm_ready` is 1.
- R2: Mailbox m occupies addresses 4m..4m+3:
  - word 0 is status: code in [27:24], length code in [19:16], timestamp in [15:0].
  - word 1 is the identifier in [28:0].
  - word 2 is payload bits 63:32; word 3 is payload bits 31:0.
  - Address 4·NMB reads the timer and address 4·NMB+1 is the flag register, bit m belonging to mailbox m.
  - The 4-bit codes are INACTIVE 0000, EMPTY 0100, FULL 0010, OVERRUN 0110 and RANSWER 1010.
  - A move-in into an EMPTY mailbox stores identifier, length, payload and `tstamp_in` as sampled when the frame was accepted, sets code FULL and raises flag m.
- R3: While a frame is being copied, bit 0 of the target's status code reads 1. The copy starts one cycle after acceptance when the target is free and lasts exactly `COPY_CYC` cycles, after which the final code appears.
- R4: A move-in into a mailbox whose code is FULL or OVERRUN leaves code OVERRUN.
- R5: A status-word read locks that mailbox when its code is FULL or OVERRUN, or EMPTY when `EMPTY_LOCKS` is 1. A frame bound for a locked mailbox is held in staging, and the mailbox contents and flag stay unchanged.
- R6: A read of the timer address, or of the status word of a different mailbox, releases the lock, after which the held frame is moved in.
- R7: Reading a status word whose code is RANSWER sets no lock and releases any existing lock.
- R8: A frame is discarded without touching the mailbox or its flag when either of these holds:
  - its target code is not EMPTY, FULL or OVERRUN when the copy would begin;
  - the CPU writes the target's status word during the copy.
- R9: Two staging slots exist. With both occupied, `frm_ready` is 0. Frames are moved in strictly in arrival order, so a frame behind a held one also waits.
- R10: Writing the flag register clears each flag whose data bit is 1 and leaves the others unchanged.
- R11: A CPU write to a status word sets the code from data bits [27:25] with bit 0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Completed frame offered |
| frm_ready | output | 1 | A staging slot is free |
| frm_idx | input | IW | Winning mailbox index |
| frm_id | input | 29 | Frame identifier |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Payload |
| tstamp_in | input | 16 | Free-running timer value |
| cpu_en | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU write when 1, read when 0 |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data (combinational) |
| irq_flag | output | NMB | Per-mailbox interrupt flags |

## Verification
The bench builds the block with four mailboxes, `COPY_CYC` of 3 and `EMPTY_LOCKS` set to 1. A copy window that short lets the bench read the busy code twice within one move-in, including on the last busy cycle, and then see the final code on the very next read. With only four mailboxes, the lock can be moved between mailboxes and released through the timer within a few accesses. A locked mailbox at the head of staging can then be combined with a second queued frame to show both the full-staging stall and the in-order release.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
    localparam int ID_W   = 29;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int TS_W   = 16;

    localparam logic [3:0] C_INACT = 4'b0000;
    localparam logic [3:0] C_EMPTY = 4'b0100;
    localparam logic [3:0] C_FULL  = 4'b0010;
    localparam logic [3:0] C_OVRN  = 4'b0110;
    localparam logic [3:0] C_RANS  = 4'b1010;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
        logic [TS_W-1:0]   ts;
    } frame_t;

    typedef struct packed {
        logic [3:0] code;
        frame_t     f;
    } mbox_t;

    // codes that accept a move-in (busy bit ignored)
    function automatic logic rx_code(input logic [3:1] c);
        return (c == C_EMPTY[3:1]) || (c == C_FULL[3:1]) || (c == C_OVRN[3:1]);
    endfunction

    // codes that lock the mailbox when the CPU reads its status word
    function automatic logic lock_code(input logic [3:1] c, input logic empty_locks);
        return (c == C_FULL[3:1]) || (c == C_OVRN[3:1]) ||
               (empty_locks && (c == C_EMPTY[3:1]));
    endfunction
endpackage

// File: rtl/rxmb_stage.sv
module rxmb_stage
    import rxmb_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  frame_t        push_frm,
    input  logic          pop,
    output logic          ready,
    output logic          head_vld,
    output logic [IW-1:0] head_idx,
    output frame_t        head_frm
);
    typedef struct packed {
        frame_t [1:0]          f;
        logic   [1:0][IW-1:0]  idx;
        logic                  rd;
        logic   [1:0]          cnt;
    } st_t;

    st_t q, n;
    logic wslot;

    always_comb begin
        n     = q;
        wslot = q.rd ^ q.cnt[0];
        if (push) begin
            n.f[wslot]   = push_frm;
            n.idx[wslot] = push_idx;
        end
        if (pop) n.rd = ~q.rd;
        case ({push, pop})
            2'b10:   n.cnt = q.cnt + 2'd1;
            2'b01:   n.cnt = q.cnt - 2'd1;
            default: n.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign ready    = (q.cnt != 2'd2);
    assign head_vld = (q.cnt != 2'd0);
    assign head_idx = q.idx[q.rd];
    assign head_frm = q.f[q.rd];

    // R9: never more than two frames staged, never pop an empty stage
    a_r9_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> q.cnt != 2'd2);
    a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> q.cnt != 2'd0);
endmodule

// File: rtl/rxmb_lock.sv
module rxmb_lock
    import rxmb_pkg::*;
#(
    parameter int IW          = 4,
    parameter bit EMPTY_LOCKS = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stat,
    input  logic [IW-1:0] rd_idx,
    input  logic [3:1]    rd_code,
    input  logic          rd_tmr,
    output logic          lock_vld,
    output logic [IW-1:0] lock_idx
);
    typedef struct packed {
        logic          vld;
        logic [IW-1:0] idx;
    } st_t;

    st_t q, n;

    always_comb begin
        n = q;
        if (rd_tmr) begin
            n.vld = 1'b0;
        end else if (rd_stat) begin
            n.vld = lock_code(rd_code, EMPTY_LOCKS);
            n.idx = rd_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign lock_vld = q.vld;
    assign lock_idx = q.idx;

    // R5: a lock only appears after a status read
    a_r5_lock_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.vld) |-> $past(rd_stat));
    // R6: a timer read always leaves the bank unlocked
    a_r6_timer_release: assert property (@(posedge clk) disable iff (!rst_n)
        rd_tmr |=> !q.vld);
endmodule

// File: rtl/rxmb_movein.sv
module rxmb_movein
    import rxmb_pkg::*;
#(
    parameter int NMB         = 16,
    parameter int COPY_CYC    = 8,
    parameter bit EMPTY_LOCKS = 1'b1,
    localparam int IW = (NMB > 1) ? $clog2(NMB) : 1,
    localparam int AW = $clog2(4 * NMB + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    output logic              frm_ready,
    input  logic [IW-1:0]     frm_idx,
    input  logic [ID_W-1:0]   frm_id,
    input  logic [DLC_W-1:0]  frm_dlc,
    input  logic [DATA_W-1:0] frm_data,
    input  logic [TS_W-1:0]   tstamp_in,
    input  logic              cpu_en,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic [NMB-1:0]    irq_flag
);
    localparam int          CW    = $clog2(COPY_CYC + 1);
    localparam logic [AW-1:0] MB_END = AW'(4 * NMB);
    localparam logic [AW-1:0] TMR_A  = AW'(4 * NMB);
    localparam logic [AW-1:0] FLG_A  = AW'(4 * NMB + 1);

    typedef struct packed {
        mbox_t [NMB-1:0] mb;
        logic  [NMB-1:0] flg;
        logic            busy;
        logic  [CW-1:0]  cnt;
        logic  [IW-1:0]  cur;
    } st_t;

    st_t q, n;

    // CPU decode
    logic [IW-1:0] acc_idx;
    logic [1:0]    word;
    logic          in_mb, rd_stat, wr_stat, rd_tmr, wr_flg, wr_mb;
    assign acc_idx = IW'(cpu_addr >> 2);
    assign word    = cpu_addr[1:0];
    assign in_mb   = (cpu_addr < MB_END);
    assign wr_mb   = cpu_en && cpu_we && in_mb;
    assign wr_stat = wr_mb && (word == 2'd0);
    assign rd_stat = cpu_en && !cpu_we && in_mb && (word == 2'd0);
    assign rd_tmr  = cpu_en && !cpu_we && (cpu_addr == TMR_A);
    assign wr_flg  = cpu_en && cpu_we && (cpu_addr == FLG_A);

    // staging
    logic          push, pop, head_vld;
    logic [IW-1:0] head_idx;
    frame_t        head_frm, in_frm;
    assign in_frm = '{id: frm_id, dlc: frm_dlc, data: frm_data, ts: tstamp_in};
    assign push   = frm_valid && frm_ready;

    rxmb_stage #(.IW(IW)) u_stage (
        .clk(clk), .rst_n(rst_n), .push(push), .push_idx(frm_idx), .push_frm(in_frm),
        .pop(pop), .ready(frm_ready), .head_vld(head_vld), .head_idx(head_idx),
        .head_frm(head_frm)
    );

    // read lock
    logic          lock_vld;
    logic [IW-1:0] lock_idx;
    logic [3:0]    acc_code;
    assign acc_code = q.mb[acc_idx].code;

    rxmb_lock #(.IW(IW), .EMPTY_LOCKS(EMPTY_LOCKS)) u_lock (
        .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .rd_idx(acc_idx),
        .rd_code(acc_code[3:1]), .rd_tmr(rd_tmr), .lock_vld(lock_vld), .lock_idx(lock_idx)
    );

    // next state
    always_comb begin
        n   = q;
        pop = 1'b0;
        if (wr_flg) n.flg = q.flg & ~cpu_wdata[NMB-1:0];
        if (q.busy) begin
            if (wr_stat && acc_idx == q.cur) begin
                n.busy = 1'b0;                       // CPU took the mailbox back: drop
                pop    = 1'b1;
            end else if (q.cnt == '0) begin
                n.mb[q.cur].code = (q.mb[q.cur].code[3:1] == C_EMPTY[3:1]) ? C_FULL : C_OVRN;
                n.mb[q.cur].f    = head_frm;
                n.flg[q.cur]     = 1'b1;
                n.busy           = 1'b0;
                pop              = 1'b1;
            end else begin
                n.cnt = q.cnt - 1'b1;
            end
        end else if (head_vld) begin
            if (!rx_code(q.mb[head_idx].code[3:1])) begin
                pop = 1'b1;                          // target not receiving: silent drop
            end else if (!(lock_vld && lock_idx == head_idx) &&
                         !(wr_stat && acc_idx == head_idx)) begin
                n.busy                  = 1'b1;
                n.cnt                   = CW'(COPY_CYC - 1);
                n.cur                   = head_idx;
                n.mb[head_idx].code[0]  = 1'b1;
            end
        end
        if (wr_mb) begin
            case (word)
                2'd0:    n.mb[acc_idx].code = {cpu_wdata[27:25], 1'b0};
                2'd1:    n.mb[acc_idx].f.id = cpu_wdata[ID_W-1:0];
                2'd2:    n.mb[acc_idx].f.data[DATA_W-1 -: 32] = cpu_wdata;
                default: n.mb[acc_idx].f.data[31:0] = cpu_wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.flg  <= '0;
            q.busy <= 1'b0;
            q.cnt  <= '0;
            q.cur  <= '0;
            for (int i = 0; i < NMB; i++) begin
                q.mb[i].code <= C_EMPTY;
                q.mb[i].f    <= '0;
            end
        end else begin
            q <= n;
        end
    end

    // read mux
    always_comb begin
        cpu_rdata = '0;
        if (in_mb) begin
            case (word)
                2'd0:    cpu_rdata = {4'b0, acc_code, 4'b0, q.mb[acc_idx].f.dlc, q.mb[acc_idx].f.ts};
                2'd1:    cpu_rdata = 32'(q.mb[acc_idx].f.id);
                2'd2:    cpu_rdata = q.mb[acc_idx].f.data[DATA_W-1 -: 32];
                default: cpu_rdata = q.mb[acc_idx].f.data[31:0];
            endcase
        end else if (cpu_addr == TMR_A) begin
            cpu_rdata = 32'(tstamp_in);
        end else if (cpu_addr == FLG_A) begin
            cpu_rdata = 32'(q.flg);
        end
    end

    assign irq_flag = q.flg;

    // ---- assertions ----
    logic [NMB-1:0] busy_vec;
    logic [CW:0]    bcnt_q;
    for (genvar i = 0; i < NMB; i++) begin : g_chk
        assign busy_vec[i] = q.mb[i].code[0];
        // R2/R4: a new flag comes with a filled mailbox
        a_r2_flag_code: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q.flg[i]) |-> (q.mb[i].code == C_FULL || q.mb[i].code == C_OVRN));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bcnt_q <= '0;
        else if (q.busy) bcnt_q <= bcnt_q + 1'b1;
        else             bcnt_q <= '0;
    end

    // R3: at most one mailbox shows busy, and no copy outlasts its window
    a_r3_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_vec));
    a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt_q <= (CW+1)'(COPY_CYC));
    // R5: a locked head never starts a copy
    a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && head_vld && lock_vld && lock_idx == head_idx) |=> !q.busy);
endmodule

// File: tb/rxmb_movein_test.sv
module rxmb_movein_test;
    localparam int NMB = 4;
    localparam int CC  = 3;
    localparam int AW  = 5;
    localparam logic [AW-1:0] TMR = 5'd16;
    localparam logic [AW-1:0] FLG = 5'd17;

    typedef struct packed {
        logic [1:0]  mb;
        logic [28:0] id;
        logic [3:0]  dlc;
        logic [63:0] data;
        logic [15:0] ts;
        logic [3:0]  code;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{2'd0, 29'h0ABC123,  4'd8,  64'h1111_2222_3333_4444, 16'h0100, 4'h2},
        '{2'd2, 29'h1FFFFFFF, 4'd0,  64'h0,                   16'hFFFF, 4'h2},
        '{2'd0, 29'h0000001,  4'd15, 64'hDEAD_BEEF_0123_4567, 16'h0200, 4'h6},
        '{2'd3, 29'h1234567,  4'd3,  64'hA5A5_5A5A_F0F0_0F0F, 16'h0300, 4'h2}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, frm_valid, frm_ready, cpu_en, cpu_we;
    logic [1:0]    frm_idx;
    logic [28:0]   frm_id;
    logic [3:0]    frm_dlc;
    logic [63:0]   frm_data;
    logic [15:0]   tstamp_in;
    logic [AW-1:0] cpu_addr;
    logic [31:0]   cpu_wdata, cpu_rdata;
    logic [NMB-1:0] irq_flag;

    rxmb_movein #(.NMB(NMB), .COPY_CYC(CC), .EMPTY_LOCKS(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_idx(frm_idx), .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_data(frm_data),
        .tstamp_in(tstamp_in), .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_flag(irq_flag)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_en = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_en = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_en = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic send(input logic [1:0] mb, input logic [28:0] id, input logic [3:0] dlc,
                        input logic [63:0] data, input logic [15:0] ts);
        @(negedge clk);
        frm_valid = 1'b1; frm_idx = mb; frm_id = id; frm_dlc = dlc;
        frm_data = data; tstamp_in = ts;
        while (!frm_ready) @(negedge clk);
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        vec_t v;
        rst_n = 1'b0; frm_valid = 1'b0; cpu_en = 1'b0; cpu_we = 1'b0;
        cpu_addr = '0; cpu_wdata = '0; frm_idx = '0; frm_id = '0; frm_dlc = '0;
        frm_data = '0; tstamp_in = '0;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 ready", 32'(frm_ready), 32'd1);
        rd(FLG, d); check("R1 flags", d, 32'd0);
        for (int m = 0; m < NMB; m++) begin
            rd(AW'(4 * m), d); check("R1 code", 32'(d[27:24]), 32'h4);
        end

        // R2/R4 table walk
        for (int k = 0; k < 4; k++) begin
            v = VEC[k];
            send(v.mb, v.id, v.dlc, v.data, v.ts);
            idle(CC + 3);
            rd(AW'(4 * v.mb + 3), d); check("R2 data lo", d, v.data[31:0]);
            rd(AW'(4 * v.mb + 2), d); check("R2 data hi", d, v.data[63:32]);
            rd(AW'(4 * v.mb + 1), d); check("R2 id", d, 32'(v.id));
            rd(FLG, d);               check("R2 flag", 32'(d[v.mb]), 32'd1);
            rd(AW'(4 * v.mb), d);
            check("R2 R4 code", 32'(d[27:24]), 32'(v.code));
            check("R2 dlc", 32'(d[19:16]), 32'(v.dlc));
            check("R2 stamp", 32'(d[15:0]), 32'(v.ts));
            wr(FLG, 32'(1) << v.mb);
        end

        // R3 busy window on mailbox 1
        send(2'd1, 29'h55, 4'd4, 64'h0000_0001_0000_B1B1, 16'h0400);
        rd(5'd4, d); check("R3 busy first", 32'(d[27:24]), 32'h5);
        rd(5'd4, d); check("R3 busy last", 32'(d[27:24]), 32'h5);
        rd(5'd4, d); check("R3 done", 32'(d[27:24]), 32'h2);
        rd(5'd7, d); check("R3 data", d, 32'h0000_B1B1);

        // R5/R6 lock on mailbox 1 (FULL, just read)
        wr(FLG, 32'h2);
        send(2'd1, 29'h56, 4'd4, 64'h0000_0002_0000_C2C2, 16'h0777);
        idle(CC + 5);
        rd(5'd7, d); check("R5 held data", d, 32'h0000_B1B1);
        rd(FLG, d);  check("R5 held flag", d, 32'd0);
        rd(TMR, d);  check("R6 timer", d, 32'h0777);
        idle(CC + 3);
        rd(5'd7, d); check("R6 released data", d, 32'h0000_C2C2);
        rd(5'd4, d); check("R4 overrun", 32'(d[27:24]), 32'h6);
        rd(FLG, d);  check("R2 flag1", d, 32'h2);
        wr(FLG, 32'h2);

        // R7/R11 RANSWER read releases mailbox 1 lock
        wr(5'd8, 32'h0A00_0000);
        send(2'd1, 29'h57, 4'd4, 64'h0000_0003_0000_D3D3, 16'h0778);
        idle(CC + 5);
        rd(5'd7, d); check("R5 still held", d, 32'h0000_C2C2);
        rd(5'd8, d); check("R11 ranswer code", 32'(d[27:24]), 32'hA);
        idle(CC + 4);
        rd(5'd7, d); check("R7 released data", d, 32'h0000_D3D3);
        wr(FLG, 32'h2);

        // R8 frame to an inactivated mailbox is dropped
        wr(5'd12, 32'h0);
        send(2'd3, 29'h58, 4'd2, 64'h0000_0004_0000_E4E4, 16'h0779);
        idle(CC + 5);
        rd(5'd15, d); check("R8 data kept", d, 32'hF0F0_0F0F);
        rd(5'd12, d); check("R8 code kept", 32'(d[27:24]), 32'h0);
        rd(FLG, d);   check("R8 no flag", d, 32'd0);
        wr(5'd12, 32'h0500_0000);
        rd(5'd12, d); check("R11 busy bit cleared", 32'(d[27:24]), 32'h4);

        // R9 two staging slots, in-order release
        wr(FLG, 32'hF);
        rd(5'd0, d);  // mailbox 0 OVERRUN: locks it
        send(2'd0, 29'h59, 4'd8, 64'h0000_0005_0000_F5F5, 16'h0780);
        send(2'd1, 29'h5A, 4'd8, 64'h0000_0006_0000_A6A6, 16'h0781);
        check("R9 ready low when full", 32'(frm_ready), 32'd0);
        idle(CC + 4);
        rd(5'd7, d);  check("R9 queued behind held", d, 32'h0000_D3D3);
        rd(TMR, d);
        idle(2 * CC + 6);
        rd(5'd3, d);  check("R9 first frame", d, 32'h0000_F5F5);
        rd(5'd7, d);  check("R9 second frame", d, 32'h0000_A6A6);
        rd(FLG, d);   check("R9 flags", d, 32'h3);

        // R10 write-one-to-clear
        wr(FLG, 32'h1);
        rd(FLG, d);   check("R10 clear bit0", d, 32'h2);
        wr(FLG, 32'h0);
        rd(FLG, d);   check("R10 zero no effect", d, 32'h2);

        finish_run();
    end
endmodule